// File: doc/BRIEF.md
# Cascadable Eight-Input Priority Interrupt Controller

This block collects up to eight interrupt request lines, ranks them by fixed priority and raises one interrupt line toward a processor. Software reaches it through a byte-wide port with two addresses, even (`addr`=0) and odd (`addr`=1). Writes to the even address carry commands. A write there with bit 4 set starts the initialisation sequence, and the odd-address writes that follow are taken as init words by their position in the sequence. Once initialised, an odd-address write loads the interrupt mask. Software acknowledges a request with a poll command instead of a bus acknowledge cycle, and it retires a request with a non-specific end-of-interrupt.

Two copies form a cascaded pair. The second copy has `slave_mode` tied high, and its `int_out` drives input 2 of the first copy. The first copy publishes the identity of a cascaded input it has acknowledged on `cas_out`/`cas_en`. The second copy answers a poll only while that identity matches the one it was given at init.

The register port has no back-pressure. Every access completes in the cycle its strobe is high, and read data is valid combinationally while `rd_en` is high. The data side effects of a read take place at the clock edge that ends it.

Top module: `pic8_core`

## Requirements
- R1: An even-address write with bit 4 set starts initialisation. It sets the mask to 0xFF, clears in-service, clears requests, ends any armed poll and selects request read-back. The following odd writes are, in order: word 2; word 3, which is skipped when bit 1 of the start byte is set; and word 4, only when bit 0 of the start byte is set. The odd write after the sequence loads the mask.
- R2: Bits 7:3 of init word 2 form the vector base. `vec_out` equals the base with the index of the highest-priority unmasked pending input in bits 2:0, or 7 when no input is pending.
- R3: Outside initialisation, an odd write loads the mask, and a 1 masks that input. An odd read returns the mask, which is 0xFF after reset.
- R4: A rising edge on an input sets its request bit. The bit clears while the input is low, when the request is acknowledged, or at init. The mask does not hide request bits from read-back.
- R5: Input 0 has the highest priority. `int_out` is high exactly when an unmasked request is pending and no in-service bit at that priority or higher is set.
- R6: Writing 0x0C to the even address arms a poll. The next even read returns {1,0000,index} of the forwarded input, sets its in-service bit and clears its request bit. The poll then ends.
- R7: A poll read with nothing forwarded returns 0x07 and leaves the in-service register unchanged.
- R8: An even write of 0x0B selects in-service read-back on even reads, and 0x0A selects request read-back. The selection persists until it is changed.
- R9: An even write of 0x20 clears the highest-priority set in-service bit.
- R10: In a non-slave, cascaded setup, a poll acknowledge of an input whose bit is set in init word 3 drives `cas_out` to its index and sets `cas_en`. Acknowledging any other input clears `cas_en`.
- R11: With `slave_mode` high, bits 2:0 of init word 3 are the identity. A poll is answered only when `cas_en_in` is high and `cas_in` equals the identity. Otherwise the read returns 0x07 and nothing is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | 0 = even (command/status), 1 = odd (init words/mask) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| irq_in | input | 8 | Interrupt request inputs, bit 0 highest priority |
| slave_mode | input | 1 | High when this copy sits behind another |
| cas_in | input | 3 | Identity published by the upstream copy |
| cas_en_in | input | 1 | Upstream identity is valid |
| int_out | output | 1 | Interrupt to processor or upstream copy |
| vec_out | output | 8 | Vector of the highest-priority pending input |
| cas_out | output | 3 | Identity of the last acknowledged cascaded input |
| cas_en | output | 1 | cas_out is valid |

## Verification
The bench builds two copies with the default `N_IN` of 8, one with `slave_mode` tied low and one tied high. The second copy's `int_out` drives input 2 of the first. With this wiring the full cascaded flow can be exercised: a slave poll refused before the master acknowledges, the master's identity hand-off, and a slave poll accepted afterwards. Eight inputs are enough to reach the lowest-priority spurious code 0x07, nested in-service blocking, and random mask/request patterns in which every priority position wins at some point.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_W2, ST_W3, ST_W4} init_st_e;
endpackage

// File: rtl/pic8_req.sv
module pic8_req #(
  parameter int N_IN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] irq_in,
  input  logic            clr_all,
  input  logic [N_IN-1:0] ack_vec,
  output logic [N_IN-1:0] irr
);
  logic [N_IN-1:0] prev_q;

  for (genvar i = 0; i < N_IN; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q[i] <= 1'b0;
        irr[i]    <= 1'b0;
      end else begin
        prev_q[i] <= irq_in[i];
        if (clr_all) irr[i] <= 1'b0;
        else irr[i] <= (irr[i] | (irq_in[i] & ~prev_q[i])) & irq_in[i] & ~ack_vec[i];
      end
    end

    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_in[i] |=> !irr[i]); // R4
    AST_REQ_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ack_vec[i] |=> !irr[i]); // R4
  end
endmodule

// File: rtl/pic8_prio.sv
module pic8_prio #(
  parameter int N_IN = 8,
  localparam int IW = $clog2(N_IN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] irr,
  input  logic [N_IN-1:0] mask,
  input  logic [N_IN-1:0] isr,
  output logic            fwd,
  output logic [IW-1:0]   idx
);
  logic [N_IN-1:0] pend;
  logic [N_IN-1:0] upto;
  logic            any;

  always_comb begin
    pend = irr & ~mask;
    idx  = IW'(N_IN - 1);
    any  = 1'b0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (pend[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
    for (int i = 0; i < N_IN; i++) upto[i] = (IW'(i) <= idx);
    fwd = any && ((isr & upto) == '0);
  end

  AST_FWD_NOT_SERVICED: assert property (@(posedge clk) disable iff (!rst_n)
    fwd |-> !isr[idx] && !mask[idx]); // R5
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
  import pic8_pkg::*;
#(
  parameter int N_IN = 8,
  localparam int IW = $clog2(N_IN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic            addr,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  input  logic [N_IN-1:0] irr,
  input  logic            fwd,
  input  logic [IW-1:0]   idx,
  input  logic            slave_mode,
  input  logic [2:0]      cas_in,
  input  logic            cas_en_in,
  output logic [N_IN-1:0] mask,
  output logic [N_IN-1:0] isr,
  output logic [7:3]      base,
  output logic [N_IN-1:0] ack_vec,
  output logic            clr_all,
  output logic [2:0]      cas_out,
  output logic            cas_en
);
  init_st_e        st;
  logic [7:0]      cfg;
  logic            rd_isr, poll_q, need4, single;
  logic            init_wr, ocw3_wr, eoi_wr, poll_rd, poll_hit, slave_ok;
  logic [N_IN-1:0] eoi_vec;
  logic [IW-1:0]   poll_idx;

  assign init_wr  = wr_en && !addr && wdata[4];
  assign ocw3_wr  = wr_en && !addr && !wdata[4] && wdata[3] && st == ST_RUN;
  assign eoi_wr   = wr_en && !addr && !wdata[4] && !wdata[3] && wdata[7:5] == 3'b001 && st == ST_RUN;
  assign slave_ok = !slave_mode || (cas_en_in && cas_in == cfg[2:0]);
  assign poll_rd  = rd_en && !addr && poll_q;
  assign poll_hit = poll_rd && fwd && slave_ok;
  assign ack_vec  = poll_hit ? (N_IN'(1) << idx) : '0;
  assign eoi_vec  = eoi_wr ? (isr & (~isr + N_IN'(1))) : '0;
  assign clr_all  = init_wr;
  assign poll_idx = (fwd && slave_ok) ? idx : IW'(N_IN - 1);

  always_comb begin
    if (addr)        rdata = mask;
    else if (poll_q) rdata = {fwd && slave_ok, {(7 - IW){1'b0}}, poll_idx};
    else if (rd_isr) rdata = isr;
    else             rdata = irr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_RUN;
      mask    <= '1;
      isr     <= '0;
      base    <= '0;
      cfg     <= '0;
      rd_isr  <= 1'b0;
      poll_q  <= 1'b0;
      need4   <= 1'b0;
      single  <= 1'b0;
      cas_out <= '0;
      cas_en  <= 1'b0;
    end else if (init_wr) begin
      st     <= ST_W2;
      mask   <= '1;
      isr    <= '0;
      rd_isr <= 1'b0;
      poll_q <= 1'b0;
      need4  <= wdata[0];
      single <= wdata[1];
      cas_en <= 1'b0;
    end else begin
      if (wr_en && addr) begin
        case (st)
          ST_RUN: mask <= wdata;
          ST_W2: begin
            base <= wdata[7:3];
            st   <= single ? (need4 ? ST_W4 : ST_RUN) : ST_W3;
          end
          ST_W3: begin
            cfg <= wdata;
            st  <= need4 ? ST_W4 : ST_RUN;
          end
          default: st <= ST_RUN;
        endcase
      end
      if (ocw3_wr) begin
        if (wdata[2]) poll_q <= 1'b1;
        if (wdata[1]) rd_isr <= wdata[0];
      end
      if (poll_rd) poll_q <= 1'b0;
      isr <= (isr | ack_vec) & ~eoi_vec;
      if (poll_hit && !slave_mode && !single) begin
        if (cfg[idx]) begin
          cas_out <= 3'(idx);
          cas_en  <= 1'b1;
        end else begin
          cas_en <= 1'b0;
        end
      end
    end
  end

  AST_INIT_MASKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    init_wr |=> mask == '1 && isr == '0); // R1
  AST_POLL_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    poll_hit && !wr_en |=> isr[$past(idx)]); // R6
  AST_SPURIOUS_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    poll_rd && !fwd && !wr_en |=> $stable(isr)); // R7
  AST_EOI_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr && isr != '0 && !rd_en |=> $countones(isr) == $countones($past(isr)) - 1); // R9
  AST_SLAVE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode && poll_rd && !cas_en_in && !wr_en |=> $stable(isr)); // R11
endmodule

// File: rtl/pic8_core.sv
module pic8_core #(
  parameter int N_IN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic            addr,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  input  logic [N_IN-1:0] irq_in,
  input  logic            slave_mode,
  input  logic [2:0]      cas_in,
  input  logic            cas_en_in,
  output logic            int_out,
  output logic [7:0]      vec_out,
  output logic [2:0]      cas_out,
  output logic            cas_en
);
  localparam int IW = $clog2(N_IN);

  logic [N_IN-1:0] irr, mask, isr, ack_vec;
  logic            clr_all, fwd;
  logic [IW-1:0]   idx;
  logic [7:3]      base;

  pic8_req #(.N_IN(N_IN)) u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr_all(clr_all),
    .ack_vec(ack_vec), .irr(irr)
  );

  pic8_prio #(.N_IN(N_IN)) u_prio (
    .clk(clk), .rst_n(rst_n), .irr(irr), .mask(mask), .isr(isr),
    .fwd(fwd), .idx(idx)
  );

  pic8_ctrl #(.N_IN(N_IN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irr(irr), .fwd(fwd), .idx(idx),
    .slave_mode(slave_mode), .cas_in(cas_in), .cas_en_in(cas_en_in),
    .mask(mask), .isr(isr), .base(base), .ack_vec(ack_vec),
    .clr_all(clr_all), .cas_out(cas_out), .cas_en(cas_en)
  );

  assign int_out = fwd;
  assign vec_out = {base, idx};

  AST_INT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr & ~mask) != '0); // R5
endmodule

// File: tb/pic8_core_tb_top.sv
`timescale 1ns/1ps
module pic8_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       m_wr = 0, m_rd = 0, m_addr = 0, s_wr = 0, s_rd = 0, s_addr = 0;
  logic [7:0] m_wdata = 0, s_wdata = 0, m_rdata, s_rdata, m_vec, s_vec;
  logic [7:0] ext = 0, s_irq = 0;
  logic       m_int, s_int, m_cas_en, s_cas_en;
  logic [2:0] m_cas_out, s_cas_out;
  logic [7:0] m_irq;
  assign m_irq = {ext[7:3], s_int, ext[1:0]};

  int checks = 0, fails = 0;
  bit done = 0;

  pic8_core dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(m_wr), .rd_en(m_rd), .addr(m_addr),
    .wdata(m_wdata), .rdata(m_rdata), .irq_in(m_irq), .slave_mode(1'b0),
    .cas_in(3'd0), .cas_en_in(1'b0), .int_out(m_int), .vec_out(m_vec),
    .cas_out(m_cas_out), .cas_en(m_cas_en)
  );

  pic8_core slv_i (
    .clk(clk), .rst_n(rst_n), .wr_en(s_wr), .rd_en(s_rd), .addr(s_addr),
    .wdata(s_wdata), .rdata(s_rdata), .irq_in(s_irq), .slave_mode(1'b1),
    .cas_in(m_cas_out), .cas_en_in(m_cas_en), .int_out(s_int), .vec_out(s_vec),
    .cas_out(s_cas_out), .cas_en(s_cas_en)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input bit sl, input bit a, input logic [7:0] d);
    @(negedge clk);
    if (sl) begin s_wr = 1; s_addr = a; s_wdata = d; end
    else    begin m_wr = 1; m_addr = a; m_wdata = d; end
    @(negedge clk);
    s_wr = 0; m_wr = 0;
  endtask

  task automatic rd(input bit sl, input bit a, output logic [7:0] d);
    @(negedge clk);
    if (sl) begin s_rd = 1; s_addr = a; end
    else    begin m_rd = 1; m_addr = a; end
    #1 d = sl ? s_rdata : m_rdata;
    @(negedge clk);
    s_rd = 0; m_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_poll(input logic [7:0] pend);
    for (int i = 0; i < 8; i++) if (pend[i]) return 8'h80 | 8'(i);
    return 8'h07;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4242));
    idle(3);
    rst_n = 1;
    idle(1);
    chk("R5 reset int", {7'd0, m_int}, 8'h00);
    rd(0, 1, d); chk("R3 reset mask", d, 8'hFF);
    rd(0, 0, d); chk("R8 reset irr readback", d, 8'h00);

    wr(0, 0, 8'h11); wr(0, 1, 8'h00); wr(0, 1, 8'h04); wr(0, 1, 8'h01);
    wr(1, 0, 8'h11); wr(1, 1, 8'h08); wr(1, 1, 8'h02); wr(1, 1, 8'h01);
    rd(0, 1, d); chk("R1 mask after init", d, 8'hFF);
    wr(0, 1, 8'hFB); wr(1, 1, 8'hFD);
    rd(0, 1, d); chk("R3 mask readback", d, 8'hFB);

    s_irq = 8'h02; idle(3);
    chk("R2 slave vector", s_vec, 8'h09);
    chk("R5 master int via cascade", {7'd0, m_int}, 8'h01);
    wr(1, 0, 8'h0C); rd(1, 0, d); chk("R11 slave poll before identity", d, 8'h07);
    wr(1, 0, 8'h0B); rd(1, 0, d); chk("R11 slave not acknowledged", d, 8'h00);
    wr(0, 0, 8'h0C); rd(0, 0, d); chk("R6 master poll cascade input", d, 8'h82);
    chk("R10 cas_out", {5'd0, m_cas_out}, 8'h02);
    chk("R10 cas_en", {7'd0, m_cas_en}, 8'h01);
    wr(1, 0, 8'h0C); rd(1, 0, d); chk("R11 slave poll matched", d, 8'h81);
    chk("R5 slave int blocked", {7'd0, s_int}, 8'h00);
    rd(1, 0, d); chk("R8 slave isr persists", d, 8'h02);
    s_irq = 8'h00;
    wr(1, 0, 8'h20); rd(1, 0, d); chk("R9 slave eoi", d, 8'h00);
    wr(0, 0, 8'h0B); rd(0, 0, d); chk("R6 master isr", d, 8'h04);
    wr(0, 0, 8'h20); rd(0, 0, d); chk("R9 master eoi", d, 8'h00);

    wr(0, 0, 8'h0A); ext = 8'h10; idle(2);
    rd(0, 0, d); chk("R4 masked input visible in irr", d, 8'h10);
    chk("R3 masked input no int", {7'd0, m_int}, 8'h00);
    ext = 8'h00; idle(2);

    wr(0, 1, 8'hBB);
    ext = 8'h40; idle(1); ext = 8'h00; idle(2);
    wr(0, 0, 8'h0C); rd(0, 0, d); chk("R7 spurious poll", d, 8'h07);
    wr(0, 0, 8'h0B); rd(0, 0, d); chk("R7 isr untouched", d, 8'h00);

    wr(0, 1, 8'h00);
    ext = 8'h08; idle(2);
    wr(0, 0, 8'h0C); rd(0, 0, d); chk("R6 poll input 3", d, 8'h83);
    chk("R10 non-cascaded clears cas_en", {7'd0, m_cas_en}, 8'h00);
    ext = 8'h28; idle(2);
    chk("R5 lower priority blocked", {7'd0, m_int}, 8'h00);
    ext = 8'h2A; idle(2);
    chk("R5 higher priority nests", {7'd0, m_int}, 8'h01);
    wr(0, 0, 8'h0C); rd(0, 0, d); chk("R6 poll input 1", d, 8'h81);
    rd(0, 0, d); chk("R8 isr nested", d, 8'h0A);
    wr(0, 0, 8'h20); rd(0, 0, d); chk("R9 eoi highest first", d, 8'h08);
    wr(0, 0, 8'h20); rd(0, 0, d); chk("R9 eoi second", d, 8'h00);
    ext = 8'h00; idle(2);

    for (int k = 0; k < 40; k++) begin
      logic [7:0] m, p, e;
      m = 8'($urandom);
      p = 8'($urandom) & 8'hFB;
      wr(0, 1, m);
      wr(0, 0, 8'h0A);
      ext = p; idle(2);
      rd(0, 0, d); chk("R4 random irr", d, p);
      chk("R5 random int", {7'd0, m_int}, {7'd0, (p & ~m) != 0});
      e = exp_poll(p & ~m);
      wr(0, 0, 8'h0C); rd(0, 0, d); chk("R6 random poll", d, e);
      wr(0, 0, 8'h0B); rd(0, 0, d);
      chk("R6 random isr", d, e[7] ? (8'h01 << e[2:0]) : 8'h00);
      wr(0, 0, 8'h20); rd(0, 0, d); chk("R9 random eoi", d, 8'h00);
      ext = 8'h00; idle(2);
    end

    wr(0, 0, 8'h13); wr(0, 1, 8'h20); wr(0, 1, 8'h01); wr(0, 1, 8'h5A);
    rd(0, 1, d); chk("R1 single skips word 3", d, 8'h5A);
    ext = 8'h20; idle(2);
    chk("R2 vector base", m_vec, 8'h25);
    wr(0, 0, 8'h0C); rd(0, 0, d); chk("R6 poll after single init", d, 8'h85);
    chk("R10 single no cas", {7'd0, m_cas_en}, 8'h00);
    ext = 8'h00; idle(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule